// File: doc/BRIEF.md
# Sequential Multiply-Divide Unit with HI/LO Result Registers

This block sits beside the integer pipeline of a 32-bit core and performs the long-latency arithmetic that the core cannot finish in one cycle. It holds two result registers, HI and LO. It accepts one request per cycle as an opcode class bit, a 6-bit function code and two operands. It can run a full multiply, a divide, a fused multiply-add or multiply-subtract on the 64-bit HI:LO pair, or a plain multiply whose low word goes back to the core. Each of these has a signed and an unsigned form where the operation calls for one.

Multiplies and divides are computed one bit per clock. An accepted long operation raises `busy`, spends one cycle preparing operand magnitudes, runs 32 iteration cycles and commits in a final cycle. Moves between the core and HI/LO take effect at once when the unit is idle. A read of HI or LO issued while a long operation is in flight raises `stall` until the result is committed. The core holds its request during the stall and is then served with the new value.

Top module: `mdu_unit`

## Requirements
- R1: After reset `busy`, `stall` and `rd_valid` are low, and HI and LO both read back as zero.
- R2: With `req_cls`=0 the codes are 0x10 read HI, 0x11 write HI, 0x12 read LO, 0x13 write LO, 0x18 signed multiply, 0x19 unsigned multiply, 0x1A signed divide and 0x1B unsigned divide. With `req_cls`=1 the codes are 0x00 signed multiply-add, 0x01 unsigned multiply-add, 0x02 plain multiply, 0x04 signed multiply-subtract and 0x05 unsigned multiply-subtract. Any other code in a class is ignored: `busy` stays low and HI/LO keep their values.
- R3: A full multiply writes the 64-bit product of `req_a` and `req_b` with its upper half in HI and its lower half in LO. Signed and unsigned forms are both supported.
- R4: A divide of `req_a` by `req_b` writes the quotient to LO and the remainder to HI. The signed form truncates toward zero, and its remainder carries the sign of the dividend.
- R5: Multiply-add replaces HI:LO with HI:LO plus the product, and multiply-subtract replaces it with HI:LO minus the product. Both wrap modulo 2^64, and each has signed and unsigned forms.
- R6: A plain multiply pulses `rd_valid` with the low 32 bits of the product in the cycle `busy` falls, and leaves HI and LO unchanged.
- R7: When the unit is idle, a write to HI or LO loads `req_a` at the accepting edge. A read returns `rd_valid` high with the register value in the cycle after acceptance.
- R8: An accepted multiply, divide, multiply-add, multiply-subtract or plain multiply raises `busy` in the next cycle. `busy` stays high for exactly 34 cycles, and the result is visible once `busy` is low.
- R9: A read of HI or LO presented while `busy` is high raises `stall` in that same cycle and produces no `rd_valid` until `busy` has fallen. The held request is then served with the committed value.
- R10: Any request other than a read of HI or LO that is presented while `busy` is high is dropped. It does not alter HI/LO and does not extend or restart the running operation.
- R11: A divide by zero takes the normal 34 busy cycles and leaves HI and LO unchanged.
- R12: A signed divide of 0x80000000 by 0xFFFFFFFF yields LO = 0x80000000 and HI = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_cls | input | 1 | Opcode class select (0 base, 1 fused) |
| req_func | input | 6 | Function code within the class |
| req_a | input | 32 | First operand (dividend, multiplicand, move source) |
| req_b | input | 32 | Second operand (divisor, multiplier) |
| busy | output | 1 | Long operation in flight |
| stall | output | 1 | Read of HI/LO held off this cycle |
| rd_valid | output | 1 | Result word for the core is valid |
| rd_data | output | 32 | Result word for the core |

## Verification
The bench targets the sign corners of the iterative datapath. These are the square of the most negative value, mixed-sign divides where truncation direction and remainder sign matter, and the most-negative-by-minus-one divide. A design that negated the wrong result, or took the remainder sign from the divisor, would return values off by sign or by one divisor. Fused operations are run with a carry out of LO and a borrow into HI, which a design that updated only LO would miss. Divide by zero must leave the preloaded HI/LO intact. A read held under `stall`, and a write plus a second start issued while busy, show whether the design returns stale data, lets a dropped request corrupt HI/LO, or restarts and lengthens the busy window.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_MULT,
    OP_DIV,
    OP_MADD,
    OP_MSUB,
    OP_MUL,
    OP_RD_HI,
    OP_RD_LO,
    OP_WR_HI,
    OP_WR_LO
  } op_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RUN,
    ST_DONE
  } mdu_state_e;

  typedef struct packed {
    op_kind_e kind;
    logic     sgn;
  } op_dec_t;

  // base class codes
  localparam logic [5:0] FN_RD_HI = 6'h10;
  localparam logic [5:0] FN_WR_HI = 6'h11;
  localparam logic [5:0] FN_RD_LO = 6'h12;
  localparam logic [5:0] FN_WR_LO = 6'h13;
  localparam logic [5:0] FN_MULS  = 6'h18;
  localparam logic [5:0] FN_MULU  = 6'h19;
  localparam logic [5:0] FN_DIVS  = 6'h1A;
  localparam logic [5:0] FN_DIVU  = 6'h1B;
  // fused class codes
  localparam logic [5:0] FN_MACS  = 6'h00;
  localparam logic [5:0] FN_MACU  = 6'h01;
  localparam logic [5:0] FN_MUL32 = 6'h02;
  localparam logic [5:0] FN_MSBS  = 6'h04;
  localparam logic [5:0] FN_MSBU  = 6'h05;

  function automatic logic is_long(op_kind_e k);
    return (k == OP_MULT) || (k == OP_DIV) || (k == OP_MADD) ||
           (k == OP_MSUB) || (k == OP_MUL);
  endfunction

endpackage

// File: rtl/mdu_decode.sv
module mdu_decode
  import mdu_pkg::*;
#(
  parameter int FW = 6
) (
  input  logic          cls,
  input  logic [FW-1:0] func,
  output op_dec_t       dec
);

  logic [5:0] fn6;
  assign fn6 = 6'(func);

  always_comb begin
    dec.kind = OP_NONE;
    dec.sgn  = 1'b0;
    if (!cls) begin
      unique case (fn6)
        FN_RD_HI: dec.kind = OP_RD_HI;
        FN_WR_HI: dec.kind = OP_WR_HI;
        FN_RD_LO: dec.kind = OP_RD_LO;
        FN_WR_LO: dec.kind = OP_WR_LO;
        FN_MULS:  begin dec.kind = OP_MULT; dec.sgn = 1'b1; end
        FN_MULU:  dec.kind = OP_MULT;
        FN_DIVS:  begin dec.kind = OP_DIV;  dec.sgn = 1'b1; end
        FN_DIVU:  dec.kind = OP_DIV;
        default:  dec.kind = OP_NONE;
      endcase
    end else begin
      unique case (fn6)
        FN_MACS:  begin dec.kind = OP_MADD; dec.sgn = 1'b1; end
        FN_MACU:  dec.kind = OP_MADD;
        FN_MUL32: begin dec.kind = OP_MUL;  dec.sgn = 1'b1; end
        FN_MSBS:  begin dec.kind = OP_MSUB; dec.sgn = 1'b1; end
        FN_MSBU:  dec.kind = OP_MSUB;
        default:  dec.kind = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/mdu_mul_seq.sv
module mdu_mul_seq #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] prod
);

  logic [2*W-1:0] acc_q;
  logic [W-1:0]   mcand_q;
  logic [W:0]     upper_sum;

  // add multiplicand into upper half when the current multiplier bit is set
  assign upper_sum = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
    end else if (load) begin
      acc_q   <= {{W{1'b0}}, mplier};
      mcand_q <= mcand;
    end else if (step) begin
      acc_q   <= {upper_sum, acc_q[W-1:1]};
    end
  end

  assign prod = acc_q;

endmodule

// File: rtl/mdu_div_seq.sv
module mdu_div_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  logic [W-1:0] rem_q, quo_q, dvs_q;
  logic [W:0]   trial, diff;
  logic         fits;

  // restoring step: shift next dividend bit into the partial remainder
  assign trial = {rem_q, quo_q[W-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign fits  = (trial >= {1'b0, dvs_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      rem_q <= '0;
      quo_q <= dividend;
      dvs_q <= divisor;
    end else if (step) begin
      rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
    end
  end

  assign quo = quo_q;
  assign rem = rem_q;

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int W  = 32,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_cls,
  input  logic [FW-1:0] req_func,
  input  logic [W-1:0]  req_a,
  input  logic [W-1:0]  req_b,
  output logic          busy,
  output logic          stall,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  op_dec_t        dec;
  mdu_state_e     st_q;
  op_kind_e       kind_q;
  logic           neg_a_q, neg_b_q;
  logic [W-1:0]   a_q, b_q;
  logic [CW-1:0]  cnt_q;
  logic [W-1:0]   hi_q, lo_q;
  logic           busy_q, rd_valid_q;
  logic [W-1:0]   rd_data_q;

  logic [W-1:0]   mag_a, mag_b;
  logic [2*W-1:0] prod_mag, prod_s, hilo;
  logic [W-1:0]   quo_mag, rem_mag, quo_s, rem_s;
  logic           eng_load, eng_step;

  mdu_decode #(.FW(FW)) u_dec (
    .cls  (req_cls),
    .func (req_func),
    .dec  (dec)
  );

  assign mag_a    = neg_a_q ? (~a_q + 1'b1) : a_q;
  assign mag_b    = neg_b_q ? (~b_q + 1'b1) : b_q;
  assign eng_load = (st_q == ST_SETUP);
  assign eng_step = (st_q == ST_RUN);

  mdu_mul_seq #(.W(W)) u_mul (
    .clk    (clk),
    .rst    (rst),
    .load   (eng_load),
    .step   (eng_step),
    .mcand  (mag_a),
    .mplier (mag_b),
    .prod   (prod_mag)
  );

  mdu_div_seq #(.W(W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .load     (eng_load),
    .step     (eng_step),
    .dividend (mag_a),
    .divisor  (mag_b),
    .quo      (quo_mag),
    .rem      (rem_mag)
  );

  // sign restoration happens in the commit cycle only
  assign prod_s = (neg_a_q ^ neg_b_q) ? (~prod_mag + 1'b1) : prod_mag;
  assign quo_s  = (neg_a_q ^ neg_b_q) ? (~quo_mag + 1'b1) : quo_mag;
  assign rem_s  = neg_a_q ? (~rem_mag + 1'b1) : rem_mag;
  assign hilo   = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      kind_q     <= OP_NONE;
      neg_a_q    <= 1'b0;
      neg_b_q    <= 1'b0;
      a_q        <= '0;
      b_q        <= '0;
      cnt_q      <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      busy_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            unique case (dec.kind)
              OP_RD_HI: begin rd_valid_q <= 1'b1; rd_data_q <= hi_q; end
              OP_RD_LO: begin rd_valid_q <= 1'b1; rd_data_q <= lo_q; end
              OP_WR_HI: hi_q <= req_a;
              OP_WR_LO: lo_q <= req_a;
              OP_MULT, OP_DIV, OP_MADD, OP_MSUB, OP_MUL: begin
                kind_q  <= dec.kind;
                a_q     <= req_a;
                b_q     <= req_b;
                neg_a_q <= dec.sgn & req_a[W-1];
                neg_b_q <= dec.sgn & req_b[W-1];
                st_q    <= ST_SETUP;
                busy_q  <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_SETUP: begin
          cnt_q <= '0;
          st_q  <= ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_STEP) st_q <= ST_DONE;
        end
        ST_DONE: begin
          unique case (kind_q)
            OP_MULT: {hi_q, lo_q} <= prod_s;
            OP_MADD: {hi_q, lo_q} <= hilo + prod_s;
            OP_MSUB: {hi_q, lo_q} <= hilo - prod_s;
            OP_MUL: begin
              rd_valid_q <= 1'b1;
              rd_data_q  <= prod_s[W-1:0];
            end
            OP_DIV: begin
              if (b_q != '0) begin
                hi_q <= rem_s;
                lo_q <= quo_s;
              end
            end
            default: ;
          endcase
          st_q   <= ST_IDLE;
          busy_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign stall    = req_valid && busy_q &&
                    ((dec.kind == OP_RD_HI) || (dec.kind == OP_RD_LO));
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W  = 32,
  parameter int FW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_cls,
  input logic [FW-1:0] req_func,
  input logic          busy,
  input logic          stall,
  input logic          rd_valid,
  input logic [W-1:0]  hi_v,
  input logic [W-1:0]  lo_v
);

  localparam int BUSY_LEN = W + 2;

  logic is_read, is_long;
  int unsigned run_len;

  assign is_read = !req_cls && ((req_func == FW'(6'h10)) || (req_func == FW'(6'h12)));
  assign is_long = (!req_cls && (req_func >= FW'(6'h18)) && (req_func <= FW'(6'h1B))) ||
                   ( req_cls && ((req_func == FW'(6'h00)) || (req_func == FW'(6'h01)) ||
                                 (req_func == FW'(6'h02)) || (req_func == FW'(6'h04)) ||
                                 (req_func == FW'(6'h05))));

  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  a_r8_busy_rises: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && is_long) |=> busy);

  a_r8_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == BUSY_LEN));

  a_r9_stall_only_when_busy: assert property (@(posedge clk) disable iff (rst)
    stall |-> busy);

  a_r9_no_result_while_busy: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !busy);

  a_r7_read_answers: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && is_read) |=> rd_valid);

  a_r10_regs_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || ($stable(hi_v) && $stable(lo_v))));

endmodule

bind mdu_unit mdu_checker #(.W(W), .FW(FW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_cls   (req_cls),
  .req_func  (req_func),
  .busy      (busy),
  .stall     (stall),
  .rd_valid  (rd_valid),
  .hi_v      (hi_q),
  .lo_v      (lo_q)
);

// File: tb/mdu_unit_tb.sv
`timescale 1ns/1ps
module mdu_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_cls = 1'b0;
  logic [5:0]  req_func = '0;
  logic [31:0] req_a = '0;
  logic [31:0] req_b = '0;
  logic        busy, stall, rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mdu_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cls(req_cls),
    .req_func(req_func), .req_a(req_a), .req_b(req_b),
    .busy(busy), .stall(stall), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  typedef struct packed {
    logic        cls;
    logic [5:0]  fn;
    logic [31:0] a, b, ihi, ilo, ehi, elo, erd;
    logic        has_rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h19, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'hFFFFFFFE, 32'h00000001, 32'h0, 1'b0, 4'd3}, // R3
    '{1'b0, 6'h18, 32'hFFFFFFFF, 32'h00000002, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h0, 1'b0, 4'd3}, // R3
    '{1'b0, 6'h18, 32'h80000000, 32'h80000000, 32'h0, 32'h0, 32'h40000000, 32'h00000000, 32'h0, 1'b0, 4'd3}, // R3
    '{1'b0, 6'h18, 32'h00001234, 32'hFFFFFFFF, 32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFEDCC, 32'h0, 1'b0, 4'd3}, // R3
    '{1'b0, 6'h1B, 32'd100,      32'd7,        32'h0, 32'h0, 32'd2,        32'd14,       32'h0, 1'b0, 4'd4}, // R4
    '{1'b0, 6'h1A, 32'hFFFFFFF9, 32'd2,        32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFD, 32'h0, 1'b0, 4'd4}, // R4
    '{1'b0, 6'h1A, 32'd7,        32'hFFFFFFFE, 32'h0, 32'h0, 32'd1,        32'hFFFFFFFD, 32'h0, 1'b0, 4'd4}, // R4
    '{1'b0, 6'h1B, 32'hFFFFFFFF, 32'd2,        32'h0, 32'h0, 32'd1,        32'h7FFFFFFF, 32'h0, 1'b0, 4'd4}, // R4
    '{1'b0, 6'h1A, 32'h80000000, 32'hFFFFFFFF, 32'h5, 32'h6, 32'h0,        32'h80000000, 32'h0, 1'b0, 4'd12}, // R12
    '{1'b0, 6'h1A, 32'd5,        32'd0,  32'h11111111, 32'h22222222, 32'h11111111, 32'h22222222, 32'h0, 1'b0, 4'd11}, // R11
    '{1'b1, 6'h00, 32'd1,        32'd1,        32'h0, 32'hFFFFFFFF, 32'h1,  32'h0,        32'h0, 1'b0, 4'd5}, // R5
    '{1'b1, 6'h00, 32'hFFFFFFFF, 32'd3,        32'h0, 32'd5,        32'h0,  32'd2,        32'h0, 1'b0, 4'd5}, // R5
    '{1'b1, 6'h01, 32'hFFFFFFFF, 32'd2,        32'h1, 32'h0,        32'h2,  32'hFFFFFFFE, 32'h0, 1'b0, 4'd5}, // R5
    '{1'b1, 6'h04, 32'd1,        32'd1,        32'h0, 32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd5}, // R5
    '{1'b1, 6'h04, 32'hFFFFFFFE, 32'd3,        32'h0, 32'd10,       32'h0,  32'h10,       32'h0, 1'b0, 4'd5}, // R5
    '{1'b1, 6'h05, 32'hFFFFFFFF, 32'd1,        32'h0, 32'h10, 32'hFFFFFFFF, 32'h00000011, 32'h0, 1'b0, 4'd5}, // R5
    '{1'b1, 6'h02, 32'h00010003, 32'h00020005, 32'hAAAAAAAA, 32'h55555555, 32'hAAAAAAAA, 32'h55555555, 32'h000B000F, 1'b1, 4'd6}, // R6
    '{1'b1, 6'h02, 32'hFFFFFFFD, 32'd5,        32'h0, 32'h0,        32'h0,  32'h0,  32'hFFFFFFF1, 1'b1, 4'd6}  // R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
    req_valid = 1'b1; req_cls = c; req_func = f; req_a = a; req_b = b;
  endtask

  task automatic write_reg(input logic [5:0] f, input logic [31:0] v);
    @(negedge clk); drive(1'b0, f, v, 32'h0);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic read_reg(input logic [5:0] f, output logic [31:0] v, output logic vld);
    @(negedge clk); drive(1'b0, f, 32'h0, 32'h0);
    @(negedge clk); vld = rd_valid; v = rd_data; req_valid = 1'b0;
  endtask

  task automatic run_op(input logic c, input logic [5:0] f, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] rd, output logic rdv, output int cyc);
    @(negedge clk); drive(c, f, a, b);
    @(negedge clk); req_valid = 1'b0;
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
    rdv = rd_valid; rd = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, rd;
    logic        vld, rdv;
    int          cyc;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 busy", {31'b0, busy}, 32'h0);
    check("R1 stall", {31'b0, stall}, 32'h0);
    check("R1 rd_valid", {31'b0, rd_valid}, 32'h0);
    read_reg(6'h10, v, vld); check("R1 HI", v, 32'h0);
    read_reg(6'h12, v, vld); check("R1 LO", v, 32'h0);

    // R7 write then read latency
    write_reg(6'h11, 32'hCAFE0001);
    read_reg(6'h10, v, vld);
    check("R7 read valid", {31'b0, vld}, 32'h1);
    check("R7 HI value", v, 32'hCAFE0001);

    // R2 unknown codes and class separation
    write_reg(6'h13, 32'h0BADF00D);
    @(negedge clk); drive(1'b0, 6'h20, 32'h1234, 32'h5);
    @(negedge clk); req_valid = 1'b0;
    check("R2 undefined base code busy", {31'b0, busy}, 32'h0);
    @(negedge clk); drive(1'b1, 6'h18, 32'h3, 32'h3);
    @(negedge clk); req_valid = 1'b0;
    check("R2 base code in fused class busy", {31'b0, busy}, 32'h0);
    read_reg(6'h10, v, vld); check("R2 HI kept", v, 32'hCAFE0001);
    read_reg(6'h12, v, vld); check("R2 LO kept", v, 32'h0BADF00D);

    // table walk: R3 R4 R5 R6 R8 R11 R12
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VEC[i].req, i);
      write_reg(6'h11, VEC[i].ihi);
      write_reg(6'h13, VEC[i].ilo);
      run_op(VEC[i].cls, VEC[i].fn, VEC[i].a, VEC[i].b, rd, rdv, cyc);
      check({tag, " R8 busy cycles"}, cyc, 34);
      check({tag, " rd_valid"}, {31'b0, rdv}, {31'b0, VEC[i].has_rd});
      if (VEC[i].has_rd) check({tag, " rd_data"}, rd, VEC[i].erd);
      read_reg(6'h10, v, vld); check({tag, " HI"}, v, VEC[i].ehi);
      read_reg(6'h12, v, vld); check({tag, " LO"}, v, VEC[i].elo);
    end

    // R9 read held under stall
    @(negedge clk); drive(1'b0, 6'h19, 32'd3, 32'd5);
    @(negedge clk); drive(1'b0, 6'h12, 32'h0, 32'h0);
    #1 check("R9 stall raised", {31'b0, stall}, 32'h1);
    vld = 1'b0;
    while (busy) begin
      if (rd_valid) vld = 1'b1;
      @(negedge clk);
    end
    check("R9 no data during stall", {31'b0, vld}, 32'h0);
    check("R9 stall dropped", {31'b0, stall}, 32'h0);
    @(negedge clk);
    check("R9 held read served", {31'b0, rd_valid}, 32'h1);
    check("R9 served new LO", rd_data, 32'd15);
    req_valid = 1'b0;

    // R10 requests dropped while busy
    write_reg(6'h11, 32'h0);
    write_reg(6'h13, 32'h0);
    @(negedge clk); drive(1'b0, 6'h19, 32'd3, 32'd5);
    @(negedge clk); drive(1'b0, 6'h13, 32'h999, 32'h0);
    cyc = 1;
    @(negedge clk); drive(1'b0, 6'h1B, 32'd100, 32'd7);
    cyc++;
    @(negedge clk); req_valid = 1'b0;
    while (busy) begin cyc++; @(negedge clk); end
    check("R10 busy not extended", cyc, 34);
    @(negedge clk);
    check("R10 no restart", {31'b0, busy}, 32'h0);
    read_reg(6'h12, v, vld); check("R10 LO from multiply", v, 32'd15);
    read_reg(6'h10, v, vld); check("R10 HI from multiply", v, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule